// File: doc/BRIEF.md
# Delay-Line Echo Stage

This block is one stage of an audio processing chain. Once per sample period a one-cycle `ready_i` pulse arrives. The stage then captures the incoming 20-bit signed sample. On the next cycle it presents either that sample alone or that sample plus half of the sample it received exactly `DEPTH` sample periods earlier. `enable_i` selects between the two. With `DEPTH` = 96000 and a 48 kHz sample rate the echo arrives two seconds late. The default depth is kept small so that the default elaboration stays light. The bench uses a depth of 16.

The delay line is a single-port style circular memory. One address register points at the oldest stored sample. That same location is read to form the echo and is then overwritten with the newly captured sample. After an accepted pulse the stage holds the write strobe for `HOLD_CYCLES` cycles. It then advances the address, wrapping at `DEPTH`, and waits one settle cycle so that the read data reflects the new address. A pulse that arrives while this sequence is running is dropped.

The memory holds nothing meaningful until it has been filled once. The echo term is forced to zero until the address has wrapped for the first time. The sum is 20 bits wide. It wraps by default, and it can instead be clamped by setting the `SATURATE` parameter.

Top module: `echo_stage`

## Requirements
- R1: After reset `sample_o` is 0, the circular address is 0 and the buffer counts as empty.
- R2: When a `ready_i` pulse is accepted with `enable_i` high and the buffer full, `sample_o` on the next cycle equals the captured sample plus the stored sample shifted right arithmetically by one bit (sign-extended, rounding toward minus infinity, e.g. -3 gives -2).
- R3: When a pulse is accepted with `enable_i` low, `sample_o` on the next cycle equals the captured sample exactly.
- R4: `sample_o` changes only on the cycle after an accepted pulse and otherwise holds its value.
- R5: After an accepted pulse the memory write strobe is high for exactly `HOLD_CYCLES` consecutive cycles, and the address stays fixed while the strobe is high. The captured sample is written regardless of `enable_i`.
- R6: After the write, the address advances by one and wraps from `DEPTH`-1 to 0. Read and write share this address, so the echo of sample n appears on sample n+`DEPTH`.
- R7: Until `DEPTH` samples have been written, the echo term is zero and the output equals the input.
- R8: Pulses must be at least `HOLD_CYCLES`+3 cycles apart. A pulse arriving earlier is ignored: the output does not change and the sample is not stored.
- R9: With `SATURATE`=0 the 21-bit sum is truncated to its low 20 bits (two's-complement wrap).
- R10: With `SATURATE`=1 a sum above 524287 gives 524287 (0x7FFFF), and a sum below -524288 gives -524288 (0x80000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | One-cycle pulse per sample period |
| enable_i | input | 1 | Adds the echo term when high |
| sample_i | input | SAMPLE_W | Incoming signed sample |
| sample_o | output | SAMPLE_W | Processed signed sample |

## Verification
The bound checker watches the sequencing on every cycle. It confirms that the output only moves after an accepted pulse and that the write strobe lasts exactly the hold length with the address frozen. It also checks that the address steps by one, wraps at the depth and stays in range. Pass-through with the stage disabled and with the buffer still empty are checked on every accepted pulse as well. The arithmetic itself can only be shown by the bench's scenarios against a reference delay line. These cover the exact `DEPTH`-sample delay, the floor-halving of odd negative samples, wrap versus clamp on overflow in both directions, and a dropped early pulse whose sample must not appear one period later.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_STEP   = 2'd2,
    ST_SETTLE = 2'd3
  } echo_state_e;
endpackage

// File: rtl/echo_ctrl.sv
module echo_ctrl
  import echo_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  output logic accept_o,
  output logic wr_en_o,
  output logic step_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  echo_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ready_i) begin
          state_d = ST_WRITE;
          cnt_d   = '0;
        end
      end
      ST_WRITE: begin
        if (cnt_q == LAST) state_d = ST_STEP;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_STEP:   state_d = ST_SETTLE;
      ST_SETTLE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign accept_o = (state_q == ST_IDLE) && ready_i;
  assign wr_en_o  = (state_q == ST_WRITE);
  assign step_o   = (state_q == ST_STEP);
endmodule

// File: rtl/echo_addr.sv
module echo_addr #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          primed_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          primed_q, primed_d;
  logic          wrap;

  assign wrap = (addr_q == TOP);

  always_comb begin
    addr_d   = addr_q;
    primed_d = primed_q;
    if (step_i) begin
      addr_d = wrap ? '0 : addr_q + 1'b1;
      if (wrap) primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      primed_q <= primed_d;
    end
  end

  assign addr_o   = addr_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/echo_ram.sv
module echo_ram #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[addr_i] <= wr_data_i;
    rd_q <= mem[addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/echo_mix.sv
module echo_mix #(
  parameter int WIDTH    = 20,
  parameter bit SATURATE = 1'b0
) (
  input  logic [WIDTH-1:0] dry_i,
  input  logic [WIDTH-1:0] delayed_i,
  input  logic             add_en_i,
  output logic [WIDTH-1:0] mix_o
);
  localparam logic signed [WIDTH:0] POS_LIM = {2'b00, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH:0] NEG_LIM = {2'b11, {(WIDTH-1){1'b0}}};

  logic signed [WIDTH:0] dry_x, half_x, sum_x;

  assign dry_x  = {dry_i[WIDTH-1], dry_i};
  assign half_x = add_en_i ? {{2{delayed_i[WIDTH-1]}}, delayed_i[WIDTH-1:1]} : '0;
  assign sum_x  = dry_x + half_x;

  generate
    if (SATURATE) begin : g_clamp
      always_comb begin
        if (sum_x > POS_LIM)      mix_o = POS_LIM[WIDTH-1:0];
        else if (sum_x < NEG_LIM) mix_o = NEG_LIM[WIDTH-1:0];
        else                      mix_o = sum_x[WIDTH-1:0];
      end
    end else begin : g_wrap
      assign mix_o = sum_x[WIDTH-1:0];
    end
  endgenerate
endmodule

// File: rtl/echo_stage.sv
module echo_stage #(
  parameter int SAMPLE_W    = 20,
  parameter int DEPTH       = 2048,
  parameter int HOLD_CYCLES = 4,
  parameter bit SATURATE    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready_i,
  input  logic                enable_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int AW = $clog2(DEPTH);

  logic                accept, wr_en, step, primed;
  logic [AW-1:0]       addr;
  logic [SAMPLE_W-1:0] in_lat_q, in_lat_d;
  logic [SAMPLE_W-1:0] out_q, out_d;
  logic [SAMPLE_W-1:0] rd_data, mixed;

  echo_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i),
    .accept_o(accept), .wr_en_o(wr_en), .step_o(step)
  );

  echo_addr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .step_i(step),
    .addr_o(addr), .primed_o(primed)
  );

  echo_ram #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_ram (
    .clk(clk), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(in_lat_q), .rd_data_o(rd_data)
  );

  echo_mix #(.WIDTH(SAMPLE_W), .SATURATE(SATURATE)) u_mix (
    .dry_i(sample_i), .delayed_i(rd_data),
    .add_en_i(enable_i & primed), .mix_o(mixed)
  );

  always_comb begin
    in_lat_d = in_lat_q;
    out_d    = out_q;
    if (accept) begin
      in_lat_d = sample_i;
      out_d    = mixed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_lat_q <= '0;
      out_q    <= '0;
    end else begin
      in_lat_q <= in_lat_d;
      out_q    <= out_d;
    end
  end

  assign sample_o = out_q;
endmodule

// File: rtl/echo_stage_chk.sv
module echo_stage_chk #(
  parameter int SAMPLE_W    = 20,
  parameter int DEPTH       = 2048,
  parameter int HOLD_CYCLES = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ready_i,
  input logic                enable_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                accept,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic                primed
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (wr_en) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  // R4: output moves only right after an accepted pulse
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(sample_o));

  // R3: disabled stage passes the sample through
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && !$past(enable_i)) |-> sample_o == $past(sample_i));

  // R7: empty buffer contributes nothing
  p_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && !$past(primed)) |-> sample_o == $past(sample_i));

  // R5: strobe length
  p_wr_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> run_q == 16'(HOLD_CYCLES));

  // R5: address frozen during write
  p_addr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $stable(addr));

  // R6: single-step advance with wrap
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |->
      addr == (($past(addr) == AW'(DEPTH - 1)) ? '0 : $past(addr) + 1'b1));

  // R6: address range
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr) < DEPTH);

  // R8: no acceptance while a write is in progress
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !accept);
endmodule

bind echo_stage echo_stage_chk #(
  .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .enable_i(enable_i),
  .sample_i(sample_i), .sample_o(sample_o), .accept(accept),
  .wr_en(wr_en), .addr(addr), .primed(primed)
);

// File: tb/echo_stage_bench.sv
module echo_stage_bench;
  localparam int W     = 20;
  localparam int DEPTH = 16;
  localparam int HOLD  = 4;

  typedef struct {
    logic [W-1:0] wrap_v;
    logic [W-1:0] sat_v;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, dout_sat;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];
  exp_t last;

  logic [W-1:0] model [DEPTH];
  int  widx = 0;
  bit  full = 0;

  always #4 clk = ~clk;

  echo_stage #(.SAMPLE_W(W), .DEPTH(DEPTH), .HOLD_CYCLES(HOLD), .SATURATE(1'b0)) u_echo_stage (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .enable_i(enable),
    .sample_i(din), .sample_o(dout)
  );

  echo_stage #(.SAMPLE_W(W), .DEPTH(DEPTH), .HOLD_CYCLES(HOLD), .SATURATE(1'b1)) u_echo_stage_sat (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .enable_i(enable),
    .sample_i(din), .sample_o(dout_sat)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  // reference delay line
  task automatic predict(input logic [W-1:0] s, input bit en, input string tag, output exp_t e);
    int sum, hv;
    hv  = (en && full) ? ($signed(model[widx]) >>> 1) : 0;
    sum = $signed(s) + hv;
    e.wrap_v = sum[W-1:0];
    if (sum > 524287)       e.sat_v = 20'h7FFFF;
    else if (sum < -524288) e.sat_v = 20'h80000;
    else                    e.sat_v = sum[W-1:0];
    e.tag = tag;
    model[widx] = s;
    if (widx == DEPTH - 1) begin widx = 0; full = 1; end
    else widx++;
  endtask

  task automatic send(input logic [W-1:0] s, input bit en, input string tag, input bit early);
    exp_t e;
    @(negedge clk);
    check(dout, last.wrap_v, "R4 hold");
    check(dout_sat, last.sat_v, "R4 hold sat");
    predict(s, en, tag, e);
    q.push_back(e);
    last = e;
    ready = 1'b1; din = s; enable = en;
    @(negedge clk);
    ready = 1'b0;
    if (early) begin
      @(negedge clk);
      q.push_back('{last.wrap_v, last.sat_v, "R8 early pulse"});
      ready = 1'b1; din = 20'h12345; enable = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      repeat (HOLD - 1) @(negedge clk);
    end else begin
      repeat (HOLD + 1) @(negedge clk);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    if (ready && rst_n) begin
      exp_t e;
      #2;
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL monitor: actual %05h expected none", dout);
      end else begin
        e = q.pop_front();
        check(dout, e.wrap_v, e.tag);
        check(dout_sat, e.sat_v, {e.tag, " sat"});
      end
    end
  end

  function automatic logic [W-1:0] pattern(input int i);
    if (i == 20 || i == 36) return 20'h7FFFF;
    if (i == 21 || i == 37) return 20'h80000;
    if (i == 3 || i == 19)  return 20'hFFFFD;
    return 20'((i * 40503 + 7919) ^ (i << 13));
  endfunction

  initial begin
    last = '{'0, '0, "reset"};
    repeat (3) @(negedge clk);
    check(dout, '0, "R1 reset output");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dout, '0, "R1 output after release");
    for (int i = 0; i < 48; i++) begin
      string tag;
      bit en;
      en = !((i % 7) == 3) || i < DEPTH;
      if (i < DEPTH)         tag = "R7 empty buffer";
      else if (!en)          tag = "R3 bypass";
      else if (i == 36)      tag = "R9 R10 positive overflow";
      else if (i == 37)      tag = "R9 R10 negative overflow";
      else if (i == 41)      tag = "R8 dropped sample not stored";
      else                   tag = "R2 R6 echo add";
      send(pattern(i), en, tag, i == 25);
    end
    repeat (HOLD + 4) @(negedge clk);
    check(dout, last.wrap_v, "R4 final hold");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule